// File: doc/BRIEF.md
# Real-Time Counter with Compare and Capture Channels

This block keeps a free-running time count that advances once per tick strobe. Software reads the count through two 32-bit windows. The fine window starts at bit 3 and gives 8 µs steps. The coarse window starts at bit 19 and gives steps of about half a second. Software can zero the count at any time. A debug option stops the count while the processor core is halted.

Two channels work on the fine window:

- **Compare channel.** Writing a target time arms it. It emits a one-cycle event when the fine time reaches the target. It also fires if the target lies no more than one second behind the current time, so a target written slightly late still fires. It disarms itself after firing.
- **Capture channel.** It stays armed until software disarms it. On each selected edge of an external pin, it stores the low bits of the fine time and emits a one-cycle event.

The event pulses feed a separate interrupt block. The tick strobe comes in already in this block's clock domain.

Top module: `rtc_cc`

## Requirements
- R1: After reset the count is zero. Each cycle with `tick_i` high adds one to the count, unless the count is frozen (R4). Register 3 reads count bits [FINE_LO+31:FINE_LO], with FINE_LO = 3 by default.
- R2: Register 4 reads count bits [COARSE_LO+31:COARSE_LO], with COARSE_LO = 19 by default.
- R3: A write of 1 in bit 0 of register 0 makes the count zero on the next cycle, and counting continues from zero. A write of 0 to that bit leaves the count unchanged.
- R4: The count is frozen when bit 0 of register 8 is 1 and `core_halted_i` is high. In every other case ticks advance it. Register 8 reads back that bit.
- R5: A write to register 5 loads the compare target and arms the compare channel. While it is armed, `cmp_event_o` pulses for one cycle in the cycle after (fine − target) mod 2^32 < PAST_WINDOW holds. PAST_WINDOW defaults to 125000, which is one second. The channel is then disarmed.
- R6: A target that is ahead of the fine time does not fire until the time reaches it. A target that is PAST_WINDOW or more behind the fine time does not fire, and the channel stays armed.
- R7: Reads of register 1 and of register 2 both return the arm state: bit 0 for the compare channel and bit 1 for the capture channel. Both bits are zero after reset.
- R8: In register 1, a write of 1 in bit 1 arms the capture channel. A write of 1 in bit 0 has no effect, and writes of 0 change nothing.
- R9: In register 2, a write of 1 in bit 0 disarms the compare channel and a write of 1 in bit 1 disarms the capture channel, in both cases with no event. If that channel's event condition holds in the same cycle, the event is still produced. Writes of 0 change nothing.
- R10: While the capture channel is armed, each selected edge of `cap_pin_i` stores fine time bits [CAP_W-1:0] in register 6, with CAP_W = 21 by default. The higher bits of register 6 read as zero. The edge is seen through a two-flop synchronizer. The store also pulses `cap_event_o` for one cycle. The channel stays armed.
- R11: Bit 0 of register 7 selects the capture edge: 0 for rising, 1 for falling. Edges of the other polarity are ignored.
- R12: While the capture channel is disarmed, edges on `cap_pin_i` leave register 6 unchanged and produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-advance strobe, one cycle per tick |
| core_halted_i | input | 1 | High while the core is stopped in debug |
| cap_pin_i | input | 1 | Asynchronous capture source |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | 4 | Register index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the index |
| cmp_event_o | output | 1 | Compare event pulse |
| cap_event_o | output | 1 | Capture event pulse |

## Verification
The embedded properties are checked on every cycle. They cover:
- the count's step, hold and zeroing rules;
- that each event pulse follows a cycle in which its channel was armed;
- that the compare channel is disarmed after it fires;
- that the capture value does not move while that channel is disarmed.

Some behaviour only the directed scenarios can show:
- the exact window boundary, including a target behind the time across the 32-bit wrap;
- the arm-clear write that lands in the same cycle as a hit;
- edge polarity selection;
- truncation of the captured time;
- the asymmetric effects of writes to the arm-set register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RTC_ADDR_W = 4;

    typedef enum logic [RTC_ADDR_W-1:0] {
        RG_CTRL    = 4'd0,
        RG_ARM_SET = 4'd1,
        RG_ARM_CLR = 4'd2,
        RG_FINE    = 4'd3,
        RG_COARSE  = 4'd4,
        RG_CMP     = 4'd5,
        RG_CAP     = 4'd6,
        RG_CAP_CFG = 4'd7,
        RG_DBG     = 4'd8
    } rtc_reg_e;

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int FINE_LO   = 3,
    parameter int COARSE_LO = 19,
    parameter int VIEW_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              freeze_i,
    input  logic              clr_i,
    output logic [VIEW_W-1:0] fine_o,
    output logic [VIEW_W-1:0] coarse_o
);
    localparam int CNT_W = COARSE_LO + VIEW_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i && !freeze_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fine_o   = st_q.cnt[FINE_LO +: VIEW_W];
    assign coarse_o = st_q.cnt[COARSE_LO +: VIEW_W];

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0)); // R3
    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !clr_i) |=> $stable(st_q.cnt)); // R4
    AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_i && !clr_i) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1))); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(st_q.cnt)); // R1

endmodule

// File: rtl/rtc_cmp_chan.sv
module rtc_cmp_chan #(
    parameter int VIEW_W      = 32,
    parameter int PAST_WINDOW = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VIEW_W-1:0] fine_i,
    input  logic              load_i,
    input  logic [VIEW_W-1:0] load_val_i,
    input  logic              disarm_i,
    output logic              armed_o,
    output logic              event_o
);
    localparam logic [VIEW_W-1:0] WIN = VIEW_W'(PAST_WINDOW);

    typedef struct packed {
        logic              armed;
        logic [VIEW_W-1:0] target;
        logic              ev;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [VIEW_W-1:0] lag;
    logic              hit;

    always_comb begin
        lag  = fine_i - st_q.target;
        hit  = st_q.armed && (lag < WIN);
        st_d = st_q;
        st_d.ev = hit;
        if (hit || disarm_i) st_d.armed = 1'b0;
        if (load_i) begin
            st_d.target = load_val_i;
            st_d.armed  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign event_o = st_q.ev;

    AST_CMP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> $past(st_q.armed)); // R5
    AST_CMP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !$past(load_i)) |-> !st_q.armed); // R5
    AST_CMP_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> st_q.armed); // R5

endmodule

// File: rtl/rtc_cap_chan.sv
module rtc_cap_chan #(
    parameter int CAP_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             fall_sel_i,
    input  logic             arm_i,
    input  logic             disarm_i,
    input  logic [CAP_W-1:0] time_i,
    output logic             armed_o,
    output logic [CAP_W-1:0] cap_o,
    output logic             event_o
);
    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             prev;
        logic             armed;
        logic [CAP_W-1:0] cap;
        logic             ev;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       edge_seen;
    logic       fire;

    always_comb begin
        edge_seen = fall_sel_i ? (st_q.prev & ~st_q.sync2)
                               : (st_q.sync2 & ~st_q.prev);
        fire      = st_q.armed && edge_seen;
        st_d       = st_q;
        st_d.sync1 = pin_i;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;
        st_d.ev    = fire;
        if (fire)     st_d.cap   = time_i;
        if (arm_i)    st_d.armed = 1'b1;
        if (disarm_i) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign cap_o   = st_q.cap;
    assign event_o = st_q.ev;

    AST_CAP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> $past(st_q.armed)); // R10
    AST_CAP_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> $stable(st_q.cap)); // R12
    AST_CAP_STAYS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !disarm_i) |=> st_q.armed); // R10

endmodule

// File: rtl/rtc_cc.sv
module rtc_cc
    import rtc_pkg::*;
#(
    parameter int FINE_LO     = 3,
    parameter int COARSE_LO   = 19,
    parameter int VIEW_W      = 32,
    parameter int CAP_W       = 21,
    parameter int PAST_WINDOW = 125000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  core_halted_i,
    input  logic                  cap_pin_i,
    input  logic                  bus_en_i,
    input  logic                  bus_we_i,
    input  logic [RTC_ADDR_W-1:0] bus_addr_i,
    input  logic [VIEW_W-1:0]     bus_wdata_i,
    output logic [VIEW_W-1:0]     bus_rdata_o,
    output logic                  cmp_event_o,
    output logic                  cap_event_o
);
    typedef struct packed {
        logic halt_en;
        logic fall_sel;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    rtc_reg_e          sel;
    logic              wr;
    logic              clr, freeze;
    logic              cmp_load, cmp_disarm, cap_arm, cap_disarm;
    logic              cmp_armed, cap_armed;
    logic [VIEW_W-1:0] fine, coarse;
    logic [CAP_W-1:0]  cap_val;

    always_comb begin
        sel        = rtc_reg_e'(bus_addr_i);
        wr         = bus_en_i && bus_we_i;
        clr        = wr && (sel == RG_CTRL) && bus_wdata_i[0];
        cap_arm    = wr && (sel == RG_ARM_SET) && bus_wdata_i[1];
        cmp_disarm = wr && (sel == RG_ARM_CLR) && bus_wdata_i[0];
        cap_disarm = wr && (sel == RG_ARM_CLR) && bus_wdata_i[1];
        cmp_load   = wr && (sel == RG_CMP);
        freeze     = cfg_q.halt_en && core_halted_i;
        cfg_d = cfg_q;
        if (wr && (sel == RG_CAP_CFG)) cfg_d.fall_sel = bus_wdata_i[0];
        if (wr && (sel == RG_DBG))     cfg_d.halt_en  = bus_wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            RG_ARM_SET, RG_ARM_CLR: bus_rdata_o = VIEW_W'({cap_armed, cmp_armed});
            RG_FINE:    bus_rdata_o = fine;
            RG_COARSE:  bus_rdata_o = coarse;
            RG_CAP:     bus_rdata_o = VIEW_W'(cap_val);
            RG_CAP_CFG: bus_rdata_o = VIEW_W'(cfg_q.fall_sel);
            RG_DBG:     bus_rdata_o = VIEW_W'(cfg_q.halt_en);
            default:    bus_rdata_o = '0;
        endcase
    end

    rtc_timebase #(
        .FINE_LO  (FINE_LO),
        .COARSE_LO(COARSE_LO),
        .VIEW_W   (VIEW_W)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .freeze_i(freeze),
        .clr_i   (clr),
        .fine_o  (fine),
        .coarse_o(coarse)
    );

    rtc_cmp_chan #(
        .VIEW_W     (VIEW_W),
        .PAST_WINDOW(PAST_WINDOW)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fine_i    (fine),
        .load_i    (cmp_load),
        .load_val_i(bus_wdata_i),
        .disarm_i  (cmp_disarm),
        .armed_o   (cmp_armed),
        .event_o   (cmp_event_o)
    );

    rtc_cap_chan #(
        .CAP_W(CAP_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (cap_pin_i),
        .fall_sel_i(cfg_q.fall_sel),
        .arm_i     (cap_arm),
        .disarm_i  (cap_disarm),
        .time_i    (fine[CAP_W-1:0]),
        .armed_o   (cap_armed),
        .cap_o     (cap_val),
        .event_o   (cap_event_o)
    );

    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_disarm && !cmp_armed) |=> !cmp_event_o); // R9
    AST_ARM_SET_BIT0_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == RG_ARM_SET) && !cmp_armed) |=> !cmp_armed); // R8

endmodule

// File: tb/rtc_cc_bench.sv
`timescale 1ns/1ps
module rtc_cc_bench;
    import rtc_pkg::*;

    localparam int B_FINE_LO   = 3;
    localparam int B_COARSE_LO = 8;
    localparam int B_CAP_W     = 4;
    localparam int B_WINDOW    = 8;

    typedef struct packed {
        logic        rd;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, RG_ARM_SET, 32'h0,   4'd7},  // R7 reset arm state
        '{1'b1, RG_ARM_CLR, 32'h0,   4'd7},  // R7
        '{1'b0, RG_ARM_SET, 32'h1,   4'd8},  // R8 bit0 write
        '{1'b1, RG_ARM_SET, 32'h0,   4'd8},  // R8 bit0 inert
        '{1'b0, RG_ARM_SET, 32'h2,   4'd8},  // R8 arm capture
        '{1'b1, RG_ARM_CLR, 32'h2,   4'd7},  // R7 alias readback
        '{1'b0, RG_ARM_SET, 32'h0,   4'd8},  // R8 zero write
        '{1'b1, RG_ARM_SET, 32'h2,   4'd8},  // R8
        '{1'b0, RG_ARM_CLR, 32'h0,   4'd9},  // R9 zero write
        '{1'b1, RG_ARM_SET, 32'h2,   4'd9},  // R9
        '{1'b0, RG_ARM_CLR, 32'h2,   4'd9},  // R9 disarm capture
        '{1'b1, RG_ARM_SET, 32'h0,   4'd9},  // R9
        '{1'b1, RG_CAP,     32'h0,   4'd10}, // R10 reset capture
        '{1'b0, RG_CMP,     32'h100, 4'd5},  // R5 load arms
        '{1'b1, RG_ARM_SET, 32'h1,   4'd5},  // R5
        '{1'b1, RG_FINE,    32'h0,   4'd6},  // R6 future target, time idle
        '{1'b0, RG_ARM_CLR, 32'h1,   4'd9},  // R9 disarm compare
        '{1'b1, RG_ARM_CLR, 32'h0,   4'd9},  // R9
        '{1'b0, RG_DBG,     32'h1,   4'd4},  // R4
        '{1'b1, RG_DBG,     32'h1,   4'd4},  // R4
        '{1'b0, RG_CAP_CFG, 32'h1,   4'd11}, // R11
        '{1'b1, RG_CAP_CFG, 32'h1,   4'd11}, // R11
        '{1'b0, RG_CAP_CFG, 32'h0,   4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        core_halted = 1'b0;
    logic        cap_pin = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmp_ev, cap_ev;

    int          n_chk = 0;
    int          n_fail = 0;
    int          n_cmp_ev = 0;
    int          n_cap_ev = 0;
    logic [63:0] exp_cnt = '0;
    logic        halt_m = 1'b0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    rtc_cc #(
        .FINE_LO    (B_FINE_LO),
        .COARSE_LO  (B_COARSE_LO),
        .VIEW_W     (32),
        .CAP_W      (B_CAP_W),
        .PAST_WINDOW(B_WINDOW)
    ) u_rtc_cc (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .core_halted_i(core_halted),
        .cap_pin_i    (cap_pin),
        .bus_en_i     (bus_en),
        .bus_we_i     (bus_we),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .cmp_event_o  (cmp_ev),
        .cap_event_o  (cap_ev)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmp_ev) n_cmp_ev++;
            if (cap_ev) n_cap_ev++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            if (!(halt_m && core_halted)) exp_cnt++;
        end
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] fine_exp();
        return exp_cnt[B_FINE_LO +: 32];
    endfunction

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        bus_read(RG_FINE, rd);   chk("R1 reset fine", rd, 32'h0);
        bus_read(RG_COARSE, rd); chk("R2 reset coarse", rd, 32'h0);
        chk("R1 reset events", {30'h0, cmp_ev, cap_ev}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rd);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].data);
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end
        halt_m = 1'b1;
        chk("R6 no compare event from future target", n_cmp_ev, 0);

        // R1 R2 counting views
        run_ticks(600);
        bus_read(RG_FINE, rd);   chk("R1 fine after 600", rd, fine_exp());
        bus_read(RG_COARSE, rd); chk("R2 coarse after 600", rd, exp_cnt[B_COARSE_LO +: 32]);

        // R3 software zeroing
        bus_write(RG_CTRL, 32'h0);
        bus_read(RG_FINE, rd);   chk("R3 zero write inert", rd, fine_exp());
        bus_write(RG_CTRL, 32'h1);
        exp_cnt = '0;
        bus_read(RG_FINE, rd);   chk("R3 cleared", rd, 32'h0);
        run_ticks(16);
        bus_read(RG_FINE, rd);   chk("R3 resumes", rd, 32'd2);

        // R4 halt freeze
        core_halted = 1'b1;
        run_ticks(40);
        bus_read(RG_FINE, rd);   chk("R4 frozen", rd, 32'd2);
        core_halted = 1'b0;
        run_ticks(8);
        bus_read(RG_FINE, rd);   chk("R4 not halted counts", rd, 32'd3);
        bus_write(RG_DBG, 32'h0);
        halt_m = 1'b0;
        core_halted = 1'b1;
        run_ticks(8);
        bus_read(RG_FINE, rd);   chk("R4 halt disabled counts", rd, 32'd4);
        core_halted = 1'b0;

        // R5 compare reach
        bus_write(RG_CTRL, 32'h1);
        exp_cnt = '0;
        bus_write(RG_CMP, 32'd2);
        run_ticks(15);
        idle(2);
        chk("R5 not yet reached", n_cmp_ev, 0);
        run_ticks(1);
        idle(2);
        chk("R5 fires on equal", n_cmp_ev, 1);
        bus_read(RG_ARM_SET, rd); chk("R5 disarmed after fire", rd, 32'h0);
        run_ticks(8);
        chk("R5 one shot", n_cmp_ev, 1);

        // fine = 3: R5 late across wrap, R6 beyond window
        bus_write(RG_CMP, 32'hFFFF_FFFE);
        idle(3);
        chk("R5 late within window fires", n_cmp_ev, 2);
        bus_write(RG_CMP, 32'hFFFF_FFFB);
        idle(3);
        chk("R6 beyond window silent", n_cmp_ev, 2);
        bus_read(RG_ARM_SET, rd); chk("R6 stays armed", rd, 32'h1);
        bus_write(RG_ARM_CLR, 32'h1);
        idle(3);
        chk("R9 disarm no event", n_cmp_ev, 2);
        bus_read(RG_ARM_CLR, rd); chk("R9 disarmed", rd, 32'h0);

        // R9 clear in the hit cycle
        bus_write(RG_CMP, 32'd3);
        bus_write(RG_ARM_CLR, 32'h1);
        idle(3);
        chk("R9 same-cycle event kept", n_cmp_ev, 3);
        bus_write(RG_CMP, 32'd5);
        bus_write(RG_ARM_CLR, 32'h1);
        run_ticks(24);
        idle(2);
        chk("R9 cleared future target silent", n_cmp_ev, 3);

        // R10 capture, rising edge, truncated to B_CAP_W bits
        run_ticks(100);
        bus_write(RG_ARM_SET, 32'h2);
        cap_pin = 1'b1;
        idle(4);
        chk("R10 capture event", n_cap_ev, 1);
        bus_read(RG_CAP, rd);     chk("R10 captured low bits", rd, fine_exp() & 32'hF);
        bus_read(RG_ARM_SET, rd); chk("R10 stays armed", rd, 32'h2);
        cap_pin = 1'b0;
        idle(4);
        chk("R11 falling ignored when rising selected", n_cap_ev, 1);

        // R11 falling select
        run_ticks(16);
        bus_write(RG_CAP_CFG, 32'h1);
        cap_pin = 1'b1;
        idle(4);
        chk("R11 rising ignored when falling selected", n_cap_ev, 1);
        cap_pin = 1'b0;
        idle(4);
        chk("R11 falling captured", n_cap_ev, 2);
        bus_read(RG_CAP, rd);     chk("R11 captured value", rd, fine_exp() & 32'hF);

        // R12 disarmed capture
        bus_write(RG_ARM_CLR, 32'h2);
        run_ticks(8);
        cap_pin = 1'b1;
        idle(4);
        cap_pin = 1'b0;
        idle(4);
        chk("R12 no event when disarmed", n_cap_ev, 2);
        bus_read(RG_CAP, rd);     chk("R12 capture unchanged", rd, 32'd4);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule